// File: doc/BRIEF.md
# UART Interrupt Status and Trigger Controller

This block collects every interrupt source of a serial port and turns them into one raw status vector, one masked status vector and a single interrupt line. Its inputs are single-cycle event strobes from the receiver, the transmitter, the modem-line watcher and the DMA engine. It also takes the current fill counts of both FIFOs, the two programmed trigger-level codes, a once-per-bit-period tick and a transmitter-idle level. It holds a mask register of its own. A clear strobe carries a write-one-to-clear vector into the raw status.

The transmit and receive interrupts compare the fill counts against thresholds that are fractions of the FIFO depth. Each one rises when its condition is entered and stays set while the condition holds. It drops when the condition goes away or when software clears it. After a clear it stays low until the condition has gone away and come back. The receive-timeout source counts bit periods while the receive FIFO holds data, and its mask bit doubles as its enable. A gate on the receive DMA request blocks transfers while a receive error is pending, if that option is selected.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the mask reads zero. A mask write loads the written value with bits 0, 2 and 3 forced to zero, so writing 0x3FFF reads back 0x3FF2. Bit positions are: modem-line change 1, receive 4, transmit 5, receive timeout 6, framing 7, parity 8, break 9, overrun 10, end of transmission 11, transmit-DMA done 12, receive-DMA done 13.
- R2: Each masked status bit equals the raw bit ANDed with the mask bit, and the interrupt output is high exactly when any masked bit is high.
- R3: In FIFO mode (fifo_en=1) the receive condition is rx_level >= threshold. Codes 0, 1, 2, 3 and 4 give 1/8, 1/4, 1/2, 3/4 and 7/8 of the depth. Reserved codes 5 to 7 act like code 2. The raw bit is set on entry into the condition and clears once the condition is left.
- R4: In FIFO mode the transmit condition is tx_level <= threshold, using the same code table, with the same set and drop rules as R3.
- R5: In character mode (fifo_en=0) the transmit condition is tx_level == 0 and the receive condition is rx_level != 0.
- R6: The receive-timeout bit is set after 32 bit ticks while rx_level != 0 with no rx_char_done. It can only become set while mask bit 6 is 1. It clears when the FIFO empties or a new character restarts the count.
- R7: The end-of-transmission bit is set on entry into (tx_level == 0 and tx_idle), and drops when that condition is left.
- R8: Framing, parity, break, overrun, modem-change and both DMA-done strobes set their raw bit, which then holds until cleared. A strobe in the same cycle as a clear of that bit leaves the bit set.
- R9: A clear strobe clears each raw bit whose clear_wdata bit is 1 and leaves bits written 0 untouched. A cleared level source stays low while its condition persists.
- R10: rx_dma_req equals rx_dma_req_in, except that it is forced low while dma_on_err is 1 and any of raw bits 7 to 10 is set.
- R11: During reset all raw bits, the masked bits and the interrupt output are zero. Raw bits update one clock after the inputs that cause them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1 = FIFO mode, 0 = single-slot character mode |
| tx_trig_sel | input | 3 | Transmit trigger-level code |
| rx_trig_sel | input | 3 | Receive trigger-level code |
| tx_level | input | LVL_W | Transmit FIFO fill count |
| rx_level | input | LVL_W | Receive FIFO fill count |
| tx_idle | input | 1 | Transmit shift register has sent its last stop bit |
| rx_char_done | input | 1 | Strobe: a character entered the receive FIFO |
| bit_tick | input | 1 | Strobe once per bit period |
| fe_evt | input | 1 | Framing error strobe |
| pe_evt | input | 1 | Parity error strobe |
| be_evt | input | 1 | Break strobe |
| oe_evt | input | 1 | Overrun strobe |
| cts_evt | input | 1 | Modem clear-to-send change strobe |
| tx_dma_done | input | 1 | Transmit DMA done strobe |
| rx_dma_done | input | 1 | Receive DMA done strobe |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | 14 | Mask write value |
| clr_wr | input | 1 | Clear write strobe |
| clr_wdata | input | 14 | Write-one-to-clear vector |
| dma_on_err | input | 1 | Block receive DMA on pending errors |
| rx_dma_req_in | input | 1 | Receive DMA request from the FIFO side |
| mask_q | output | 14 | Current mask |
| raw_status | output | 14 | Raw interrupt status |
| masked_status | output | 14 | Masked interrupt status |
| irq | output | 1 | Combined interrupt |
| rx_dma_req | output | 1 | Gated receive DMA request |

## Verification
Some rules are checked by assertions on every cycle: the set, drop and clear rules of every status cell, the bound and restart of the timeout counter, the mask as a precondition for the timeout bit, and the DMA gate. The threshold table, including the reserved codes and the end points of each fraction, can only be shown by the bench's scenarios. So can the switch between character and FIFO mode, saturation of the timeout counter while its mask is off, and the strobe-versus-clear collision. A behavioural model in the bench predicts every output on every cycle across those scenarios.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

   localparam int IRQ_W = 14;

   localparam int B_CTS   = 1;
   localparam int B_RX    = 4;
   localparam int B_TX    = 5;
   localparam int B_RT    = 6;
   localparam int B_FE    = 7;
   localparam int B_PE    = 8;
   localparam int B_BE    = 9;
   localparam int B_OE    = 10;
   localparam int B_EOT   = 11;
   localparam int B_TXDMA = 12;
   localparam int B_RXDMA = 13;

   // implemented bits of the status and mask vectors
   localparam logic [IRQ_W-1:0] IRQ_VALID = 14'h3FF2;
   // sources that follow a condition rather than latch a strobe
   localparam logic [IRQ_W-1:0] IRQ_LEVEL = 14'h0870;
   // receive error sources that can hold off receive DMA
   localparam logic [IRQ_W-1:0] IRQ_ERR   = 14'h0780;

   typedef enum logic [2:0] {
      TRIG_EIGHTH  = 3'd0,
      TRIG_QUARTER = 3'd1,
      TRIG_HALF    = 3'd2,
      TRIG_3QUART  = 3'd3,
      TRIG_7EIGHTH = 3'd4
   } trig_code_e;

endpackage

// File: rtl/uart_irq_thresh.sv
module uart_irq_thresh
   import uart_irq_pkg::*;
#(
   parameter int DEPTH    = 16,
   parameter int LVL_W    = 5,
   parameter bit AT_LEAST = 1'b1
) (
   input  logic             fifo_en,
   input  logic [2:0]       sel,
   input  logic [LVL_W-1:0] level,
   output logic             cond
);

   localparam logic [LVL_W-1:0] T_EIGHTH  = LVL_W'(DEPTH / 8);
   localparam logic [LVL_W-1:0] T_QUARTER = LVL_W'(DEPTH / 4);
   localparam logic [LVL_W-1:0] T_HALF    = LVL_W'(DEPTH / 2);
   localparam logic [LVL_W-1:0] T_3QUART  = LVL_W'((DEPTH * 3) / 4);
   localparam logic [LVL_W-1:0] T_7EIGHTH = LVL_W'((DEPTH * 7) / 8);

   logic [LVL_W-1:0] thr;
   logic             fifo_hit;
   logic             slot_hit;

   always_comb begin
      case (sel)
         TRIG_EIGHTH:  thr = T_EIGHTH;
         TRIG_QUARTER: thr = T_QUARTER;
         TRIG_HALF:    thr = T_HALF;
         TRIG_3QUART:  thr = T_3QUART;
         TRIG_7EIGHTH: thr = T_7EIGHTH;
         default:      thr = T_HALF;
      endcase
   end

   generate
      if (AT_LEAST) begin : g_fill
         assign fifo_hit = (level >= thr);
         assign slot_hit = (level != '0);
      end else begin : g_drain
         assign fifo_hit = (level <= thr);
         assign slot_hit = (level == '0);
      end
   endgenerate

   assign cond = fifo_en ? fifo_hit : slot_hit;

endmodule

// File: rtl/uart_irq_timeout.sv
module uart_irq_timeout #(
   parameter int LIMIT = 32,
   localparam int CW   = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic nonempty,
   input  logic char_done,
   input  logic tick,
   output logic expired
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!nonempty || char_done) begin
         cnt_q <= '0;
      end else if (tick && (cnt_q != CW'(LIMIT))) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expired = nonempty && (cnt_q == CW'(LIMIT));

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(LIMIT)); // R6
   AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (char_done || !nonempty) |=> (cnt_q == '0)); // R6

endmodule

// File: rtl/uart_irq_src.sv
module uart_irq_src #(
   parameter bit LEVEL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   input  logic clr,
   output logic raw
);

   logic raw_q;

   generate
      if (LEVEL) begin : g_level
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q <= 1'b0;
               raw_q  <= 1'b0;
            end else begin
               prev_q <= trig;
               raw_q  <= trig & (~prev_q | (raw_q & ~clr));
            end
         end

         AST_LEVEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
            !trig |=> !raw_q); // R3
         AST_LEVEL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
            (trig && !prev_q) |=> raw_q); // R3
         AST_LEVEL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && prev_q) |=> !raw_q); // R9
      end else begin : g_sticky
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) raw_q <= 1'b0;
            else        raw_q <= trig | (raw_q & ~clr);
         end

         AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
            trig |=> raw_q); // R8
         AST_STICKY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && !trig) |=> !raw_q); // R9
      end
   endgenerate

   assign raw = raw_q;

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
   import uart_irq_pkg::*;
#(
   parameter int FIFO_DEPTH   = 16,
   parameter int TIMEOUT_BITS = 32,
   localparam int LVL_W       = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_en,
   input  logic [2:0]       tx_trig_sel,
   input  logic [2:0]       rx_trig_sel,
   input  logic [LVL_W-1:0] tx_level,
   input  logic [LVL_W-1:0] rx_level,
   input  logic             tx_idle,
   input  logic             rx_char_done,
   input  logic             bit_tick,
   input  logic             fe_evt,
   input  logic             pe_evt,
   input  logic             be_evt,
   input  logic             oe_evt,
   input  logic             cts_evt,
   input  logic             tx_dma_done,
   input  logic             rx_dma_done,
   input  logic             mask_wr,
   input  logic [13:0]      mask_wdata,
   input  logic             clr_wr,
   input  logic [13:0]      clr_wdata,
   input  logic             dma_on_err,
   input  logic             rx_dma_req_in,
   output logic [13:0]      mask_q,
   output logic [13:0]      raw_status,
   output logic [13:0]      masked_status,
   output logic             irq,
   output logic             rx_dma_req
);

   generate
      if (FIFO_DEPTH < 8 || (FIFO_DEPTH % 8) != 0) begin : g_bad_depth
         $error("FIFO_DEPTH must be a multiple of 8");
      end
      if (TIMEOUT_BITS < 1) begin : g_bad_timeout
         $error("TIMEOUT_BITS must be at least 1");
      end
   endgenerate

   logic [IRQ_W-1:0] mask_r;
   logic [IRQ_W-1:0] trig;
   logic [IRQ_W-1:0] clr_vec;
   logic [IRQ_W-1:0] raw;
   logic             tx_cond;
   logic             rx_cond;
   logic             rt_expired;
   logic             rt_cond;
   logic             eot_cond;
   logic             err_hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_r <= '0;
      else if (mask_wr) mask_r <= mask_wdata & IRQ_VALID;
   end

   uart_irq_thresh #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W), .AT_LEAST(1'b0)) u_tx_thr (
      .fifo_en (fifo_en),
      .sel     (tx_trig_sel),
      .level   (tx_level),
      .cond    (tx_cond)
   );

   uart_irq_thresh #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W), .AT_LEAST(1'b1)) u_rx_thr (
      .fifo_en (fifo_en),
      .sel     (rx_trig_sel),
      .level   (rx_level),
      .cond    (rx_cond)
   );

   uart_irq_timeout #(.LIMIT(TIMEOUT_BITS)) u_timeout (
      .clk       (clk),
      .rst_n     (rst_n),
      .nonempty  (rx_level != '0),
      .char_done (rx_char_done),
      .tick      (bit_tick),
      .expired   (rt_expired)
   );

   // the timeout mask doubles as its enable
   assign rt_cond  = rt_expired & mask_r[B_RT];
   assign eot_cond = (tx_level == '0) & tx_idle;

   always_comb begin
      trig          = '0;
      trig[B_CTS]   = cts_evt;
      trig[B_RX]    = rx_cond;
      trig[B_TX]    = tx_cond;
      trig[B_RT]    = rt_cond;
      trig[B_FE]    = fe_evt;
      trig[B_PE]    = pe_evt;
      trig[B_BE]    = be_evt;
      trig[B_OE]    = oe_evt;
      trig[B_EOT]   = eot_cond;
      trig[B_TXDMA] = tx_dma_done;
      trig[B_RXDMA] = rx_dma_done;
   end

   assign clr_vec = clr_wr ? (clr_wdata & IRQ_VALID) : '0;

   generate
      for (genvar i = 0; i < IRQ_W; i++) begin : g_src
         uart_irq_src #(.LEVEL(IRQ_LEVEL[i])) u_src (
            .clk   (clk),
            .rst_n (rst_n),
            .trig  (trig[i]),
            .clr   (clr_vec[i]),
            .raw   (raw[i])
         );
      end
   endgenerate

   assign raw_status    = raw & IRQ_VALID;
   assign mask_q        = mask_r;
   assign masked_status = raw_status & mask_r;
   assign irq           = |masked_status;
   assign err_hold      = dma_on_err & (|(raw_status & IRQ_ERR));
   assign rx_dma_req    = rx_dma_req_in & ~err_hold;

   AST_DMA_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_on_err && (|raw_status[B_OE:B_FE])) |-> !rx_dma_req); // R10
   AST_RT_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw_status[B_RT]) |-> $past(mask_r[B_RT])); // R6
   AST_RESERVED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_status[0] == 1'b0) && (raw_status[3:2] == 2'b00)); // R1

endmodule

// File: tb/test_uart_irq_ctrl.sv
`timescale 1ns/1ps
module test_uart_irq_ctrl;

   localparam int DEPTH = 16;
   localparam int LW    = $clog2(DEPTH + 1);
   localparam int TOUT  = 32;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          fifo_en;
   logic [2:0]    tx_trig_sel, rx_trig_sel;
   logic [LW-1:0] tx_level, rx_level;
   logic          tx_idle, rx_char_done, bit_tick;
   logic          fe_evt, pe_evt, be_evt, oe_evt, cts_evt, tx_dma_done, rx_dma_done;
   logic          mask_wr, clr_wr;
   logic [13:0]   mask_wdata, clr_wdata;
   logic          dma_on_err, rx_dma_req_in;
   logic [13:0]   mask_q, raw_status, masked_status;
   logic          irq, rx_dma_req;

   int tests = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   uart_irq_ctrl #(.FIFO_DEPTH(DEPTH), .TIMEOUT_BITS(TOUT)) i_uart_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
      .tx_trig_sel(tx_trig_sel), .rx_trig_sel(rx_trig_sel),
      .tx_level(tx_level), .rx_level(rx_level), .tx_idle(tx_idle),
      .rx_char_done(rx_char_done), .bit_tick(bit_tick),
      .fe_evt(fe_evt), .pe_evt(pe_evt), .be_evt(be_evt), .oe_evt(oe_evt),
      .cts_evt(cts_evt), .tx_dma_done(tx_dma_done), .rx_dma_done(rx_dma_done),
      .mask_wr(mask_wr), .mask_wdata(mask_wdata), .clr_wr(clr_wr), .clr_wdata(clr_wdata),
      .dma_on_err(dma_on_err), .rx_dma_req_in(rx_dma_req_in),
      .mask_q(mask_q), .raw_status(raw_status), .masked_status(masked_status),
      .irq(irq), .rx_dma_req(rx_dma_req)
   );

   // ---------------- behavioural reference model ----------------
   logic [13:0] m_raw, m_mask;
   int          m_cnt;
   bit          m_prev_tx, m_prev_rx, m_prev_eot, m_prev_rt;

   function automatic int thr_of(input logic [2:0] code);
      case (code)
         3'd0: return DEPTH / 8;
         3'd1: return DEPTH / 4;
         3'd3: return DEPTH * 3 / 4;
         3'd4: return DEPTH * 7 / 8;
         default: return DEPTH / 2;
      endcase
   endfunction

   function automatic string req_of(input int b);
      case (b)
         4: return "R3";
         5: return "R4";
         6: return "R6";
         11: return "R7";
         default: return "R8";
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_raw = '0; m_mask = '0; m_cnt = 0;
         m_prev_tx = 0; m_prev_rx = 0; m_prev_eot = 0; m_prev_rt = 0;
      end else begin
         bit c_tx, c_rx, c_eot, c_rt;
         logic [13:0] clr, ev, nxt;
         c_tx  = fifo_en ? (int'(tx_level) <= thr_of(tx_trig_sel)) : (tx_level == 0);
         c_rx  = fifo_en ? (int'(rx_level) >= thr_of(rx_trig_sel)) : (rx_level != 0);
         c_eot = (tx_level == 0) && tx_idle;
         c_rt  = (rx_level != 0) && (m_cnt == TOUT) && m_mask[6];
         clr   = clr_wr ? clr_wdata : 14'h0;
         ev    = '0;
         ev[1] = cts_evt; ev[7] = fe_evt; ev[8] = pe_evt; ev[9] = be_evt;
         ev[10] = oe_evt; ev[12] = tx_dma_done; ev[13] = rx_dma_done;
         nxt = ev | (m_raw & ~clr & 14'h3782);
         nxt[5]  = c_tx  && (!m_prev_tx  || (m_raw[5]  && !clr[5]));
         nxt[4]  = c_rx  && (!m_prev_rx  || (m_raw[4]  && !clr[4]));
         nxt[11] = c_eot && (!m_prev_eot || (m_raw[11] && !clr[11]));
         nxt[6]  = c_rt  && (!m_prev_rt  || (m_raw[6]  && !clr[6]));
         m_raw = nxt;
         m_prev_tx = c_tx; m_prev_rx = c_rx; m_prev_eot = c_eot; m_prev_rt = c_rt;
         if (rx_level == 0 || rx_char_done) m_cnt = 0;
         else if (bit_tick && m_cnt < TOUT) m_cnt = m_cnt + 1;
         if (mask_wr) m_mask = mask_wdata & 14'h3FF2;
      end
   end

   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         logic [13:0] e_masked;
         logic        e_dma;
         e_masked = m_raw & m_mask;
         e_dma    = rx_dma_req_in && !(dma_on_err && ((m_raw & 14'h0780) != 0));
         for (int b = 0; b < 14; b++) begin
            tests++;
            if (raw_status[b] !== m_raw[b]) begin
               fails++;
               $display("FAIL %s raw bit %0d: actual %0b expected %0b", req_of(b), b, raw_status[b], m_raw[b]);
            end
         end
         tests++;
         if (mask_q !== m_mask) begin
            fails++; $display("FAIL R1 mask: actual %h expected %h", mask_q, m_mask);
         end
         tests++;
         if (masked_status !== e_masked || irq !== (e_masked != 0)) begin
            fails++; $display("FAIL R2 masked/irq: actual %h/%0b expected %h/%0b",
                              masked_status, irq, e_masked, e_masked != 0);
         end
         tests++;
         if (rx_dma_req !== e_dma) begin
            fails++; $display("FAIL R10 dma gate: actual %0b expected %0b", rx_dma_req, e_dma);
         end
      end
   end

   // ---------------- directed scenarios ----------------
   task automatic step(input int n = 1);
      repeat (n) begin @(posedge clk); @(negedge clk); end
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic write_mask(input logic [13:0] v);
      mask_wr = 1; mask_wdata = v; step(); mask_wr = 0;
   endtask

   task automatic write_clr(input logic [13:0] v);
      clr_wr = 1; clr_wdata = v; step(); clr_wr = 0; clr_wdata = '0;
   endtask

   task automatic ticks(input int n);
      bit_tick = 1; step(n); bit_tick = 0;
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n = 0; fifo_en = 0; tx_trig_sel = 3'd2; rx_trig_sel = 3'd2;
      tx_level = '0; rx_level = '0; tx_idle = 1; rx_char_done = 0; bit_tick = 0;
      fe_evt = 0; pe_evt = 0; be_evt = 0; oe_evt = 0; cts_evt = 0;
      tx_dma_done = 0; rx_dma_done = 0; mask_wr = 0; mask_wdata = '0;
      clr_wr = 0; clr_wdata = '0; dma_on_err = 0; rx_dma_req_in = 0;
      repeat (3) @(negedge clk);
      chk("R11 reset raw", raw_status, 14'h0);
      chk("R11 reset irq", irq, 1'b0);
      chk("R1 reset mask", mask_q, 14'h0);
      rst_n = 1;
      step();
      chk("R5 R7 empty tx after reset", raw_status, 14'h0820);
      chk("R2 irq masked off", irq, 1'b0);

      write_mask(14'h3FFF);
      chk("R1 mask reserved bits", mask_q, 14'h3FF2);
      chk("R2 masked copy", masked_status, 14'h0820);
      chk("R2 irq on", irq, 1'b1);

      write_clr(14'h0020);
      chk("R9 clear tx", raw_status, 14'h0800);
      step(3);
      chk("R9 cleared stays low", raw_status, 14'h0800);
      write_clr(14'h0000);
      chk("R9 zero write no effect", raw_status, 14'h0800);

      tx_level = 1; tx_idle = 0; step();
      chk("R7 eot drops", raw_status, 14'h0000);
      tx_level = 0; step();
      chk("R5 tx slot empty", raw_status, 14'h0020);
      rx_level = 1; step();
      chk("R5 rx slot full", raw_status, 14'h0030);
      rx_level = 0; step();
      chk("R5 rx slot read", raw_status, 14'h0020);
      tx_idle = 1; step();
      chk("R7 eot set", raw_status, 14'h0820);

      fifo_en = 1; tx_level = 9; step();
      chk("R4 above half", raw_status, 14'h0000);
      tx_level = 8; step();
      chk("R4 at half", raw_status[5], 1'b1);
      tx_trig_sel = 3'd1; step();
      chk("R4 above quarter", raw_status[5], 1'b0);
      tx_trig_sel = 3'd3; step();
      chk("R4 below 3/4", raw_status[5], 1'b1);

      rx_trig_sel = 3'd1; rx_level = 3; step();
      chk("R3 below quarter", raw_status[4], 1'b0);
      rx_level = 4; step();
      chk("R3 at quarter", raw_status[4], 1'b1);
      rx_trig_sel = 3'd3; step();
      chk("R3 below 3/4", raw_status[4], 1'b0);
      rx_level = 12; step();
      chk("R3 at 3/4", raw_status[4], 1'b1);
      write_clr(14'h0010);
      chk("R9 clear rx", raw_status[4], 1'b0);
      rx_level = 13; step();
      chk("R9 rx stays cleared", raw_status[4], 1'b0);
      rx_trig_sel = 3'd4; step();
      rx_level = 14; step();
      chk("R3 at 7/8", raw_status[4], 1'b1);
      rx_trig_sel = 3'd6; rx_level = 7; step();
      chk("R3 reserved below half", raw_status[4], 1'b0);
      rx_level = 8; step();
      chk("R3 reserved at half", raw_status[4], 1'b1);
      rx_trig_sel = 3'd0; rx_level = 2; step();
      chk("R3 at 1/8", raw_status[4], 1'b1);

      rx_char_done = 1; step(); rx_char_done = 0;
      ticks(TOUT - 1); step();
      chk("R6 one tick short", raw_status[6], 1'b0);
      ticks(1); step();
      chk("R6 timeout set", raw_status[6], 1'b1);
      rx_char_done = 1; step(); rx_char_done = 0; step();
      chk("R6 new char restarts", raw_status[6], 1'b0);
      ticks(TOUT); step();
      chk("R6 timeout again", raw_status[6], 1'b1);
      write_clr(14'h0040); step(2);
      chk("R9 timeout cleared", raw_status[6], 1'b0);
      write_mask(14'h3FB2);
      rx_char_done = 1; step(); rx_char_done = 0;
      ticks(TOUT + 8); step();
      chk("R6 gated by mask", raw_status[6], 1'b0);
      write_mask(14'h3FF2); step();
      chk("R6 mask enables", raw_status[6], 1'b1);
      rx_level = 0; step();
      chk("R6 empty clears", raw_status[6], 1'b0);

      dma_on_err = 1; rx_dma_req_in = 1; step();
      chk("R10 no error passes", rx_dma_req, 1'b1);
      fe_evt = 1; step(); fe_evt = 0;
      chk("R8 framing set", raw_status[7], 1'b1);
      chk("R10 error blocks", rx_dma_req, 1'b0);
      write_clr(14'h0080);
      chk("R10 cleared passes", rx_dma_req, 1'b1);
      pe_evt = 1; clr_wr = 1; clr_wdata = 14'h0100; step();
      pe_evt = 0; clr_wr = 0; clr_wdata = '0;
      chk("R8 strobe beats clear", raw_status[8], 1'b1);
      dma_on_err = 0; step();
      chk("R10 option off", rx_dma_req, 1'b1);
      be_evt = 1; oe_evt = 1; cts_evt = 1; tx_dma_done = 1; rx_dma_done = 1; step();
      be_evt = 0; oe_evt = 0; cts_evt = 0; tx_dma_done = 0; rx_dma_done = 0;
      chk("R8 all strobes", raw_status & 14'h3782, 14'h3702 | 14'h0100);
      write_clr(14'h3FFF);
      chk("R9 clear all", raw_status, 14'h0000);

      write_mask(14'h0000);
      fe_evt = 1; step(); fe_evt = 0;
      chk("R2 masked off", masked_status, 14'h0000);
      chk("R2 irq off", irq, 1'b0);
      step(2);
      finish_run();
   end

endmodule